// File: doc/BRIEF.md
# Fault Register Interrupt Aggregator

This block gathers the error strobes of a processor board into one 16-bit sticky fault register. The sources are memory protection, memory parity, bus timeout, the software watchdog, and the backplane system-failure line. A fault can set a different bit depending on the kind of bus cycle it occurred in. Every recorded fault sends a one-cycle pulse to set the processor's pending interrupt level 1. Some faults also send a one-cycle instruction-abort request. A power-fail input is handled separately: its assertion edge pulses pending interrupt level 0, and no enable can mask that pulse.

Software reads the register value directly from the `faultReg` output. It clears chosen bits by pulsing a clear strobe together with a bit mask. A fault that arrives in the same cycle as a clear is always kept, so a read followed by a clear cannot lose an error. All fault strobes are active low and are sampled synchronously. The system-failure and power-fail inputs are levels; only their assertion (falling) edges count as events. All outputs are registered: an input sampled at a rising clock edge shows its effect on the outputs directly after that same edge.

Top module: `fault_aggregator`

## Requirements
- R1: After reset, `faultReg` is 0x0000 and `pendLvl1`, `pendLvl0` and `abortReq` are all low.
- R2: A low `protErrN` sets bit 0 when `cpuMemCyc` is high and requests an abort. It sets bit 1 when `dmaCyc` is high, with no abort. With neither qualifier high it sets nothing.
- R3: A low `parErrN` sets bit 2, regardless of cycle type, and does not request an abort.
- R4: A low `busTmoN` sets bit 4 when `cpuMemCyc` is high and bit 5 when `ioCyc` is high. Either case requests an abort.
- R5: A low `wdogN` sets both bit 13 and bit 15.
- R6: A falling edge on `sysFailN` sets bit 7 only while `sysFailEn` is high. If the enable is low, or the line simply stays low, nothing is recorded.
- R7: `pendLvl1` pulses high for exactly the cycle that follows any input cycle in which at least one fault bit was set. It stays low otherwise.
- R8: A falling edge on `pwrFailN` pulses `pendLvl0` high for one cycle. No enable gates this pulse, and it leaves `faultReg` unchanged.
- R9: Fault bits are sticky. A bit goes to 0 only when `swClr` is high and the matching bit of `swClrMask` is 1. A fault set in the same cycle as a clear of that bit wins, so the bit stays 1.
- R10: The effect of an input sampled at a rising edge is visible on all outputs right after that edge, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| protErrN | input | 1 | Memory protect error strobe, active low |
| parErrN | input | 1 | Memory parity error strobe, active low |
| busTmoN | input | 1 | Bus timeout strobe, active low |
| wdogN | input | 1 | Software watchdog expiry strobe, active low |
| sysFailN | input | 1 | Backplane system-failure level, active low |
| pwrFailN | input | 1 | Power-fail level, active low |
| cpuMemCyc | input | 1 | Current cycle is a CPU memory cycle |
| dmaCyc | input | 1 | Current cycle is a DMA cycle |
| ioCyc | input | 1 | Current cycle is an I/O cycle |
| sysFailEn | input | 1 | Enables recording of system failure |
| swClr | input | 1 | Software clear strobe |
| swClrMask | input | 16 | Bits to clear when `swClr` is high |
| faultReg | output | 16 | Fault register value |
| pendLvl1 | output | 1 | Pulse that sets pending interrupt level 1 |
| pendLvl0 | output | 1 | Pulse that sets pending interrupt level 0 |
| abortReq | output | 1 | Pulse requesting an instruction abort |

## Verification
Each strobe is tried under every cycle qualifier, so the tests can tell the CPU-memory, DMA and I/O bit choices apart, and can separate aborting faults from non-aborting ones. The system-failure and power-fail levels are held low over several cycles, with the enable both low and high, to separate edge-triggered capture from level capture. Clears are applied with partial masks, and also in the same cycle as a new fault. This shows that clearing is selective and that set wins over clear. A final cycle asserts every source at once to check that the contributions are merged.

// File: rtl/fault_agg_pkg.sv
package fault_agg_pkg;
  localparam int FAULT_W = 16;
  localparam int BIT_PROT_CPU = 0;
  localparam int BIT_PROT_DMA = 1;
  localparam int BIT_PARITY = 2;
  localparam int BIT_TMO_MEM = 4;
  localparam int BIT_TMO_IO = 5;
  localparam int BIT_SYSFAIL = 7;
  localparam int BIT_WDOG_LO = 13;
  localparam int BIT_WDOG_HI = 15;

  typedef struct packed {
    logic [FAULT_W-1:0] setMask;
    logic faultEvt;
    logic abortEvt;
    logic pwrEvt;
  } faultEvt_t;
endpackage

// File: rtl/fault_ctrl.sv
module fault_ctrl
  import fault_agg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      protErrN,
  input  logic      parErrN,
  input  logic      busTmoN,
  input  logic      wdogN,
  input  logic      sysFailN,
  input  logic      pwrFailN,
  input  logic      cpuMemCyc,
  input  logic      dmaCyc,
  input  logic      ioCyc,
  input  logic      sysFailEn,
  output faultEvt_t evt
);
  logic prevSysFailN;
  logic prevPwrFailN;
  logic sysFailEdge;
  logic pwrFailEdge;
  logic protCpu;
  logic tmoAny;

  // Level inputs: remember last sample to detect assertion edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevSysFailN <= 1'b1;
      prevPwrFailN <= 1'b1;
    end else begin
      prevSysFailN <= sysFailN;
      prevPwrFailN <= pwrFailN;
    end
  end

  assign sysFailEdge = prevSysFailN & ~sysFailN;
  assign pwrFailEdge = prevPwrFailN & ~pwrFailN;
  assign protCpu = ~protErrN & cpuMemCyc;
  assign tmoAny = ~busTmoN & (cpuMemCyc | ioCyc);

  always_comb begin
    evt = '0;
    evt.setMask[BIT_PROT_CPU] = protCpu;
    evt.setMask[BIT_PROT_DMA] = ~protErrN & dmaCyc;
    evt.setMask[BIT_PARITY] = ~parErrN;
    evt.setMask[BIT_TMO_MEM] = ~busTmoN & cpuMemCyc;
    evt.setMask[BIT_TMO_IO] = ~busTmoN & ioCyc;
    evt.setMask[BIT_SYSFAIL] = sysFailEdge & sysFailEn;
    evt.setMask[BIT_WDOG_LO] = ~wdogN;
    evt.setMask[BIT_WDOG_HI] = ~wdogN;
    evt.faultEvt = |evt.setMask;
    evt.abortEvt = protCpu | tmoAny;
    evt.pwrEvt = pwrFailEdge;
  end

  // R6: a held-low line never yields two capture events in a row
  assert_sysfail_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sysFailEdge |=> !sysFailEdge);
endmodule

// File: rtl/fault_datapath.sv
module fault_datapath
  import fault_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  faultEvt_t          evt,
  input  logic               swClr,
  input  logic [FAULT_W-1:0] swClrMask,
  output logic [FAULT_W-1:0] faultReg,
  output logic               pendLvl1,
  output logic               pendLvl0,
  output logic               abortReq
);
  logic [FAULT_W-1:0] clrBits;
  assign clrBits = swClr ? swClrMask : '0;

  // One sticky cell per bit: set has priority over clear.
  for (genvar b = 0; b < FAULT_W; b++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) faultReg[b] <= 1'b0;
      else if (evt.setMask[b]) faultReg[b] <= 1'b1;
      else if (clrBits[b]) faultReg[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendLvl1 <= 1'b0;
      pendLvl0 <= 1'b0;
      abortReq <= 1'b0;
    end else begin
      pendLvl1 <= evt.faultEvt;
      pendLvl0 <= evt.pwrEvt;
      abortReq <= evt.abortEvt;
    end
  end

  // R9: without a clear no bit can fall
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !swClr |=> ((faultReg & $past(faultReg)) == $past(faultReg)));
  // R2/R4: an abort always comes with an aborting fault bit recorded
  assert_abort_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abortReq |-> (faultReg[BIT_PROT_CPU] | faultReg[BIT_TMO_MEM] | faultReg[BIT_TMO_IO]));
  // R7: level-1 pulse implies a nonzero fault register
  assert_lvl1_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pendLvl1 |-> (faultReg != '0));
  // R5: the watchdog pair rises together
  assert_wdog_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(faultReg[BIT_WDOG_LO]) |-> faultReg[BIT_WDOG_HI]);
  // R8: power-fail pulse lasts one cycle
  assert_lvl0_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pendLvl0 |=> !pendLvl0);
  // R1: outputs quiet in reset
  always_comb begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (faultReg == '0 && !pendLvl1 && !pendLvl0 && !abortReq);
    end
  end
endmodule

// File: rtl/fault_aggregator.sv
module fault_aggregator
  import fault_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               protErrN,
  input  logic               parErrN,
  input  logic               busTmoN,
  input  logic               wdogN,
  input  logic               sysFailN,
  input  logic               pwrFailN,
  input  logic               cpuMemCyc,
  input  logic               dmaCyc,
  input  logic               ioCyc,
  input  logic               sysFailEn,
  input  logic               swClr,
  input  logic [FAULT_W-1:0] swClrMask,
  output logic [FAULT_W-1:0] faultReg,
  output logic               pendLvl1,
  output logic               pendLvl0,
  output logic               abortReq
);
  faultEvt_t evt;

  fault_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .protErrN(protErrN), .parErrN(parErrN), .busTmoN(busTmoN), .wdogN(wdogN),
    .sysFailN(sysFailN), .pwrFailN(pwrFailN),
    .cpuMemCyc(cpuMemCyc), .dmaCyc(dmaCyc), .ioCyc(ioCyc),
    .sysFailEn(sysFailEn), .evt(evt)
  );

  fault_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .swClr(swClr), .swClrMask(swClrMask),
    .faultReg(faultReg), .pendLvl1(pendLvl1), .pendLvl0(pendLvl0), .abortReq(abortReq)
  );
endmodule

// File: tb/fault_aggregator_tb.sv
module fault_aggregator_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic protErrN = 1, parErrN = 1, busTmoN = 1, wdogN = 1, sysFailN = 1, pwrFailN = 1;
  logic cpuMemCyc = 0, dmaCyc = 0, ioCyc = 0, sysFailEn = 0, swClr = 0;
  logic [15:0] swClrMask = '0;
  logic [15:0] faultReg;
  logic pendLvl1, pendLvl0, abortReq;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [15:0] reg16;
    logic l1;
    logic l0;
    logic ab;
    string tag;
  } item_t;
  item_t sbq[$];

  logic [15:0] expReg = '0;
  logic prevSys = 1'b0;
  logic prevPwr = 1'b0;

  always #5 clk = ~clk;

  fault_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .protErrN(protErrN), .parErrN(parErrN), .busTmoN(busTmoN),
    .wdogN(wdogN), .sysFailN(sysFailN), .pwrFailN(pwrFailN), .cpuMemCyc(cpuMemCyc),
    .dmaCyc(dmaCyc), .ioCyc(ioCyc), .sysFailEn(sysFailEn), .swClr(swClr),
    .swClrMask(swClrMask), .faultReg(faultReg), .pendLvl1(pendLvl1),
    .pendLvl0(pendLvl0), .abortReq(abortReq)
  );

  // Driver: drive one input cycle at negedge and push the expected outputs.
  task automatic step(input bit prot, input bit par, input bit tmo, input bit wd,
                      input bit sysF, input bit pwr, input bit cpu, input bit dma,
                      input bit io, input bit en, input bit clr, input logic [15:0] mask,
                      input string tag);
    logic [15:0] setB;
    bit sysEdge, pwrEdge;
    item_t it;
    @(negedge clk);
    protErrN = ~prot; parErrN = ~par; busTmoN = ~tmo; wdogN = ~wd;
    sysFailN = ~sysF; pwrFailN = ~pwr; cpuMemCyc = cpu; dmaCyc = dma; ioCyc = io;
    sysFailEn = en; swClr = clr; swClrMask = mask;
    setB = '0;
    if (prot && cpu) setB[0] = 1'b1;
    if (prot && dma) setB[1] = 1'b1;
    if (par) setB[2] = 1'b1;
    if (tmo && cpu) setB[4] = 1'b1;
    if (tmo && io) setB[5] = 1'b1;
    if (wd) begin setB[13] = 1'b1; setB[15] = 1'b1; end
    sysEdge = sysF && !prevSys;
    pwrEdge = pwr && !prevPwr;
    prevSys = sysF;
    prevPwr = pwr;
    if (sysEdge && en) setB[7] = 1'b1;
    expReg = (expReg & ~(clr ? mask : 16'h0000)) | setB;
    it.reg16 = expReg;
    it.l1 = (setB != 16'h0000);
    it.l0 = pwrEdge;
    it.ab = (prot && cpu) || (tmo && (cpu || io));
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0,0,0,0,0,0,0,0,0,0,0,16'h0000,tag);
  endtask

  // Monitor: after each rising edge compare against the oldest expected item.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t e;
        e = sbq.pop_front();
        checks++;
        if (faultReg !== e.reg16 || pendLvl1 !== e.l1 || pendLvl0 !== e.l0 || abortReq !== e.ab) begin
          fails++;
          $display("FAIL %s: got reg=%h l1=%b l0=%b ab=%b, expected reg=%h l1=%b l0=%b ab=%b",
                   e.tag, faultReg, pendLvl1, pendLvl0, abortReq, e.reg16, e.l1, e.l0, e.ab);
        end
      end
    end
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (faultReg !== 16'h0000 || pendLvl1 !== 1'b0 || pendLvl0 !== 1'b0 || abortReq !== 1'b0) begin
      fails++;
      $display("FAIL R1: got reg=%h l1=%b l0=%b ab=%b, expected all zero",
               faultReg, pendLvl1, pendLvl0, abortReq);
    end
    rst_n = 1'b1;
    idle("R1 idle after reset");
    //        pr pa to wd sf pw cp dm io en cl mask
    step(1,0,0,0,0,0,1,0,0,0,0,16'h0000,"R2 protect in CPU cycle, R10 latency");
    step(1,0,0,0,0,0,0,1,0,0,0,16'h0000,"R2 protect in DMA cycle");
    step(1,0,0,0,0,0,0,0,0,0,0,16'h0000,"R2 protect without qualifier");
    step(0,0,0,0,0,0,0,0,0,0,1,16'hFFFF,"R9 clear all");
    step(0,1,0,0,0,0,0,1,0,0,0,16'h0000,"R3 parity");
    step(0,0,1,0,0,0,1,0,0,0,0,16'h0000,"R4 timeout memory");
    step(0,0,1,0,0,0,0,0,1,0,0,16'h0000,"R4 timeout io");
    step(0,0,0,1,0,0,0,0,0,0,0,16'h0000,"R5 watchdog");
    idle("R7 no event idle");
    step(0,0,0,0,1,0,0,0,0,0,0,16'h0000,"R6 sysfail edge disabled");
    step(0,0,0,0,1,0,0,0,0,1,0,16'h0000,"R6 sysfail held low enabled");
    idle("R6 sysfail released");
    step(0,0,0,0,1,0,0,0,0,1,0,16'h0000,"R6 sysfail edge enabled");
    step(0,0,0,0,1,0,0,0,0,1,0,16'h0000,"R6 sysfail held no repeat");
    idle("R6 release");
    step(0,0,0,0,0,1,0,0,0,0,0,16'h0000,"R8 power fail edge");
    step(0,0,0,0,0,1,0,0,0,0,0,16'h0000,"R8 power fail held");
    idle("R8 release");
    step(0,0,0,0,0,0,0,0,0,0,1,16'h0030,"R9 partial clear");
    step(0,1,0,0,0,0,0,0,0,0,1,16'hFFFF,"R9 clear with same-cycle parity");
    step(0,0,0,0,0,0,0,0,0,0,1,16'hFFFF,"R9 clear all again");
    step(1,1,1,1,1,1,1,1,1,1,0,16'h0000,"R7 all sources together");
    idle("R7 final idle");
    idle("R9 sticky hold");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule